// File: doc/BRIEF.md
# Latency-Insensitive Relay Station

This block is a single pipeline stage that sits on a point-to-point channel between two synchronous modules. The channel has three parts. A data word and a valid flag travel forward; the valid flag marks a real packet, and a packet without it is a void. A stop signal travels backward. The relay registers each forward packet for one cycle. It also registers the downstream stop and drives the result upstream one cycle later, so long wires can be split without changing what the channel carries.

A stall is declared only after two observations in a row of backpressure. The two observations are the stop the relay is already driving upstream and the stop it currently receives from downstream. While the stall register is set, the relay holds its data register and emits void packets. It drops the invalid flag again one cycle after the backpressure goes away.

Top module: `relay_station`

## Requirements
- R1: During synchronous reset and on the first cycle after it, `up_stop` is 1 and `dn_valid` is 0. The internal stall state is clear, so the first packet offered after reset passes unless two stop observations have already been made.
- R2: On every rising clock edge out of reset, `up_stop` takes the value that `dn_stop` had at that edge. Backpressure therefore reaches upstream one cycle late.
- R3: On every edge out of reset, the stall state becomes the AND of the current `up_stop` and the current `dn_stop`. The stall state acts on the next edge.
- R4: When the stall state is clear at an edge, `dn_data` and `dn_valid` take the values of `up_data` and `up_valid` at that edge.
- R5: When the stall state is set at an edge, `dn_data` keeps its previous value and `dn_valid` becomes 0 (a void packet).
- R6: A `dn_stop` pulse lasting one cycle, with `dn_stop` low on the cycles around it, never produces a void packet.
- R7: After `dn_stop` falls at the end of a stall, exactly one more void packet is emitted. The packet offered on the following cycle passes.
- R8: The data width is set by the parameter `DATA_W`, which defaults to 32 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock for all state |
| rst | input | 1 | Synchronous reset, active high |
| up_data | input | DATA_W | Data word arriving from upstream |
| up_valid | input | 1 | Upstream packet is real (1) or void (0) |
| up_stop | output | 1 | Registered backpressure sent upstream |
| dn_data | output | DATA_W | Registered data word sent downstream |
| dn_valid | output | 1 | Downstream packet is real (1) or void (0) |
| dn_stop | input | 1 | Backpressure arriving from downstream |

## Verification
Every 4-cycle pattern of `dn_stop` and `up_valid` is applied, each with its own data words. This covers isolated stop pulses, runs of two or more stops, and stop edges that fall on valid and on void inputs. Isolated stop pulses show that a single observation of backpressure does not stall (R6). Runs of two or more stops produce voids while the data register holds (R5). Directed sequences also check the extra void after the stop falls (R7), and a check on the reset state (R1) separates reset behaviour from normal passing.

// File: rtl/relay_pkg.sv
package relay_pkg;

  // Backpressure has to be seen twice in a row: once on the registered
  // upstream stop and once on the live downstream stop.
  function automatic logic stall_next(input logic stop_held, input logic stop_live);
    return stop_held & stop_live;
  endfunction

  // Valid flag leaving the stage: a stalled stage emits a void.
  function automatic logic valid_next(input logic stalled, input logic valid_in);
    return valid_in & ~stalled;
  endfunction

endpackage

// File: rtl/relay_bp_path.sv
module relay_bp_path
  import relay_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic seen_run,
  input  logic dn_stop,
  output logic up_stop,
  output logic stall
);

  logic stall_d;
  assign stall_d = stall_next(up_stop, dn_stop);

  always_ff @(posedge clk) begin
    if (rst) begin
      up_stop <= 1'b1;
      stall   <= 1'b0;
    end else begin
      up_stop <= dn_stop;
      stall   <= stall_d;
    end
  end

  // R2: the stop goes upstream one cycle late
  a_r2_stop_delay: assert property (@(posedge clk) disable iff (rst)
    seen_run |-> (up_stop == $past(dn_stop)));

  // R3: stall needs two observations of backpressure
  a_r3_stall_and: assert property (@(posedge clk) disable iff (rst)
    seen_run |-> (stall == ($past(up_stop) && $past(dn_stop))));

  // R1: the reset state is visible on the first cycle after reset
  a_r1_reset_stop: assert property (@(posedge clk) disable iff (rst)
    !seen_run |-> (up_stop && !stall));

endmodule

// File: rtl/relay_fwd_reg.sv
module relay_fwd_reg
  import relay_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              seen_run,
  input  logic              stall,
  input  logic [DATA_W-1:0] up_data,
  input  logic              up_valid,
  output logic [DATA_W-1:0] dn_data,
  output logic              dn_valid
);

  logic load_en;
  assign load_en = ~stall;

  always_ff @(posedge clk) begin
    if (rst) begin
      dn_data  <= '0;
      dn_valid <= 1'b0;
    end else begin
      dn_valid <= valid_next(stall, up_valid);
      if (load_en) dn_data <= up_data;
    end
  end

  // R4: with no stall the packet passes unchanged
  a_r4_pass: assert property (@(posedge clk) disable iff (rst)
    (seen_run && !$past(stall)) |->
      (dn_valid == $past(up_valid) && dn_data == $past(up_data)));

  // R5: while stalled the stage emits voids and holds its data
  a_r5_void_hold: assert property (@(posedge clk) disable iff (rst)
    (seen_run && $past(stall)) |-> (!dn_valid && $stable(dn_data)));

  // R1: no valid packet leaves on the first cycle after reset
  a_r1_reset_valid: assert property (@(posedge clk) disable iff (rst)
    !seen_run |-> !dn_valid);

endmodule

// File: rtl/relay_station.sv
module relay_station
  import relay_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] up_data,
  input  logic              up_valid,
  output logic              up_stop,
  output logic [DATA_W-1:0] dn_data,
  output logic              dn_valid,
  input  logic              dn_stop
);

  // Set once an edge has passed with reset low, so that $past has history.
  logic seen_run;
  logic stall;

  always_ff @(posedge clk) begin
    if (rst) seen_run <= 1'b0;
    else     seen_run <= 1'b1;
  end

  relay_bp_path u_bp (
    .clk      (clk),
    .rst      (rst),
    .seen_run (seen_run),
    .dn_stop  (dn_stop),
    .up_stop  (up_stop),
    .stall    (stall)
  );

  relay_fwd_reg #(.DATA_W(DATA_W)) u_fwd (
    .clk      (clk),
    .rst      (rst),
    .seen_run (seen_run),
    .stall    (stall),
    .up_data  (up_data),
    .up_valid (up_valid),
    .dn_data  (dn_data),
    .dn_valid (dn_valid)
  );

  // R6: one stop pulse with low stop around it never causes a void
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (seen_run && !$past(up_stop)) |-> !stall);

endmodule

// File: tb/relay_station_tb.sv
`timescale 1ns/1ps
module relay_station_tb;
  localparam int DATA_W = 32;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic [DATA_W-1:0] up_data = '0;
  logic              up_valid = 1'b0;
  logic              dn_stop = 1'b0;
  logic              up_stop;
  logic [DATA_W-1:0] dn_data;
  logic              dn_valid;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  // bench model state
  logic              m_stop, m_stall, m_valid;
  logic [DATA_W-1:0] m_data;
  logic              prev_stall;

  always #10 clk = ~clk;

  relay_station #(.DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst(rst), .up_data(up_data), .up_valid(up_valid),
    .up_stop(up_stop), .dn_data(dn_data), .dn_valid(dn_valid), .dn_stop(dn_stop)
  );

  task automatic check(input string tag, input logic [DATA_W-1:0] act,
                       input logic [DATA_W-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // Apply one input cycle, update the model, then compare the outputs.
  task automatic step(input logic [DATA_W-1:0] d, input logic v, input logic s);
    logic n_stop, n_stall, n_valid;
    logic [DATA_W-1:0] n_data;
    up_data = d; up_valid = v; dn_stop = s;
    @(posedge clk);
    n_stop  = s;
    n_stall = m_stop & s;
    n_valid = m_stall ? 1'b0 : v;
    n_data  = m_stall ? m_data : d;
    prev_stall = m_stall;
    m_stop = n_stop; m_stall = n_stall; m_valid = n_valid; m_data = n_data;
    @(negedge clk);
    check("R2 up_stop", up_stop, m_stop);
    if (prev_stall) begin
      check("R5 void valid", dn_valid, 1'b0);
      check("R5 data held", dn_data, m_data);
    end else begin
      check("R4 valid pass", dn_valid, m_valid);
      check("R4 data pass", dn_data, m_data);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; up_valid = 1'b0; dn_stop = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_stop = 1'b1; m_stall = 1'b0; m_valid = 1'b0; m_data = '0;
    check("R1 reset up_stop", up_stop, 1'b1);
    check("R1 reset dn_valid", dn_valid, 1'b0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin : main
    int voids;
    @(negedge clk);
    do_reset();
    // R1: first packet after reset with no stop passes
    step(32'hA5A5_0001, 1'b1, 1'b0);
    check("R1 first packet", dn_valid, 1'b1);

    // R3: stop right after reset sees up_stop=1, so stall follows
    do_reset();
    step(32'h11, 1'b1, 1'b1);
    step(32'h22, 1'b1, 1'b0);
    check("R3 void after reset stop", dn_valid, 1'b0);
    check("R3 data held", dn_data, 32'h11);

    // R6: isolated single stop pulse gives no voids
    do_reset();
    step(32'h1, 1'b1, 1'b0);
    voids = 0;
    for (int i = 0; i < 4; i++) begin
      step(32'h100 + i, 1'b1, (i == 1));
      if (!dn_valid) voids++;
    end
    check("R6 voids on single pulse", voids, 0);

    // R7: exactly one void after stop falls
    for (int i = 0; i < 3; i++) step(32'h200 + i, 1'b1, 1'b1);
    step(32'h300, 1'b1, 1'b0);
    check("R7 void after release", dn_valid, 1'b0);
    step(32'h301, 1'b1, 1'b0);
    check("R7 resume valid", dn_valid, 1'b1);
    check("R7 resume data", dn_data, 32'h301);

    // R8: full-width data passes
    step({DATA_W{1'b1}}, 1'b1, 1'b0);
    check("R8 full width", dn_data, {DATA_W{1'b1}});

    // Sweep: every 4-cycle pattern of stop and valid
    for (int p = 0; p < 256; p++) begin
      for (int k = 0; k < 4; k++)
        step(32'h9E37_79B9 * (p * 4 + k + 1), p[2*k], p[2*k+1]);
    end
    step(32'h0, 1'b0, 1'b0);
    step(32'h0, 1'b0, 1'b0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule